// File: doc/BRIEF.md
# Locked Index/Data Configuration Port

This block is the configuration front end of a legacy I/O controller. A host reaches it over a byte-wide I/O bus through two addresses: an index port that names a configuration register, and a data port that reads or writes the register so named. The space stays closed after reset. Writes have no effect and the data port reads back all ones until a four-byte unlock key has been written, in order, to the index port.

Once the space is open, a small set of global registers is visible. These are a logical device selector and the read-only chip identity and revision. Next to them is a register bank for each logical device, selected by the device selector. Each bank holds an enable bit, a 16-bit base address and a short window of device-specific bytes. The contents of every bank are presented on output buses, and the logical devices themselves are driven from those buses. Writing 0x02 to the index port and then 0x02 to the data port closes the space again. Bank contents survive the relock.

Top module: `sio_cfg_port`

## Requirements
- R1: After a synchronous active-low reset the space is locked (`cfg_unlocked` = 0), the index and the device selector are 0x00, and every bank's enable, base and device-specific bytes are zero.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x2E) unlocks the space. `cfg_unlocked` rises on the clock edge that takes the fourth byte.
- R3: While locked, a byte that breaks the key sequence restarts detection. If that byte is 0x87 it counts as the first key byte. Key bytes written to the data port (0x2F) do not count.
- R4: While locked, reads of either port return 0xFF, data port writes change no register, and index port writes do not change the index.
- R5: While unlocked, an index port write sets the index and an index port read returns it. A data port read returns the selected register in the same cycle as `io_rd`, and a data port write updates it on that clock edge.
- R6: Register 0x20 reads CHIP_ID[15:8], 0x21 reads CHIP_ID[7:0], and 0x22 reads the 4-bit revision in bits 3:0 with bits 7:4 zero. Writes to these three registers have no effect.
- R7: Register 0x07 is a readable and writable 8-bit device selector. Bank registers refer to the bank it selects. When it is NUM_LDN or more, bank writes are ignored and bank reads return 0x00.
- R8: Register 0x30 of a bank stores bit 0 of the written byte, which drives `dev_active[ldn]`. It reads back as {7'b0, bit}.
- R9: Registers 0x60 (high byte) and 0x61 (low byte) of a bank form the 16-bit base on `dev_base[16*ldn +: 16]`.
- R10: Registers 0x70 to 0x70+NUM_SPEC-1 of a bank are read/write bytes. Byte k of bank n drives `dev_spec[8*(n*NUM_SPEC+k) +: 8]`.
- R11: A data port write of 0x02 while the index is 0x02 relocks the space on that edge. Any other value written at index 0x02 leaves it unlocked. Bank outputs keep their values across the relock.
- R12: A read in the same cycle as a write to the same port returns the state from before that write.
- R13: While unlocked, any index not listed in R6 to R10 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data, valid in the cycle `io_rd` is high |
| cfg_unlocked | output | 1 | Configuration space is open |
| dev_active | output | NUM_LDN | Enable bit per logical device |
| dev_base | output | 16*NUM_LDN | Base address per logical device |
| dev_spec | output | 8*NUM_SPEC*NUM_LDN | Device-specific bytes per logical device |

## Verification
A read and a write can hit the same port in one cycle, and that includes the write that closes the space or changes a bank byte. The bench provokes this by raising `io_rd` and `io_wr` together on the data port in two cases. In the first, the write is the exit command. Here the read must return the unlocked value of register 0x02, 0x00, and not the locked 0xFF. In the second, the write changes a base byte, and the read must return the old byte. The same check is made on the index port. A separate read in the following cycle must then show the new state.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and types for the locked configuration port.
// Assumes byte-wide register indices and a fixed four-byte unlock key.
package sio_cfg_pkg;

    // Key detector state: number of key bytes matched, or open.
    typedef enum logic [2:0] {
        KEY_0    = 3'd0,
        KEY_1    = 3'd1,
        KEY_2    = 3'd2,
        KEY_3    = 3'd3,
        KEY_OPEN = 3'd4
    } key_state_e;

    localparam logic [7:0] KEY_FIRST   = 8'h87;
    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] VAL_EXIT    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;

    // Expected key byte for a given match count.
    function automatic logic [7:0] key_byte(input key_state_e st);
        case (st)
            KEY_0:   key_byte = 8'h87;
            KEY_1:   key_byte = 8'h01;
            KEY_2:   key_byte = 8'h55;
            KEY_3:   key_byte = 8'h55;
            default: key_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sio_key_fsm.sv
// Lock state machine. It tracks the unlock key on index port writes
// while locked, opens after the last key byte and closes on an exit request.
// Assumes idx_wr is a single-cycle strobe per host byte.
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       exit_req,
    output logic       unlocked
);

    key_state_e st_q;

    // Advance, restart or relock the key detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= KEY_0;
        end else if (st_q == KEY_OPEN) begin
            if (exit_req) st_q <= KEY_0;
        end else if (idx_wr) begin
            if (wdata == key_byte(st_q))
                st_q <= key_state_e'(st_q + 3'd1);
            else if (wdata == KEY_FIRST)
                st_q <= KEY_1;
            else
                st_q <= KEY_0;
        end
    end

    assign unlocked = (st_q == KEY_OPEN);

endmodule

// File: rtl/sio_bank_regs.sv
// One logical device bank: enable bit, 16-bit base and a window of
// device-specific bytes. The caller qualifies wr_en with the unlock state
// and the device selection. The read data is combinational on idx.
module sio_bank_regs
    import sio_cfg_pkg::*;
#(
    parameter int         NUM_SPEC  = 4,
    parameter logic [7:0] SPEC_BASE = 8'h70,
    localparam int        SPEC_W    = NUM_SPEC * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        idx,
    input  logic [7:0]        wdata,
    output logic              active,
    output logic [15:0]       base,
    output logic [SPEC_W-1:0] spec,
    output logic [7:0]        rd_data
);

    logic        act_q;
    logic [15:0] base_q;
    logic [7:0]  spec_q [NUM_SPEC];

    // Fixed registers of the bank: enable and base address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            base_q <= 16'h0000;
        end else if (wr_en) begin
            case (idx)
                IDX_ACT:     act_q        <= wdata[0];
                IDX_BASE_HI: base_q[15:8] <= wdata;
                IDX_BASE_LO: base_q[7:0]  <= wdata;
                default:     ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_SPEC; k++) begin : g_spec
        // Device-specific byte k, written at its own index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                spec_q[k] <= 8'h00;
            else if (wr_en && idx == 8'(SPEC_BASE + k))
                spec_q[k] <= wdata;
        end
        assign spec[8*k +: 8] = spec_q[k];
    end

    // Read mux over the bank's registers; unmapped indices read zero.
    always_comb begin
        rd_data = 8'h00;
        case (idx)
            IDX_ACT:     rd_data = {7'b0, act_q};
            IDX_BASE_HI: rd_data = base_q[15:8];
            IDX_BASE_LO: rd_data = base_q[7:0];
            default: begin
                for (int k = 0; k < NUM_SPEC; k++)
                    if (idx == 8'(SPEC_BASE + k)) rd_data = spec_q[k];
            end
        endcase
    end

    assign active = act_q;
    assign base   = base_q;

endmodule

// File: rtl/sio_cfg_port.sv
// Index/data configuration port with key unlock and per-device banking.
// It decodes the two host ports, holds the index and device selector,
// answers the read-only identity registers and routes accesses to the
// selected bank. Reads are combinational, writes take effect on the edge.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F,
    parameter logic [15:0] CHIP_ID    = 16'h8716,
    parameter logic [3:0]  CHIP_REV   = 4'h3,
    parameter int          NUM_LDN    = 4,
    parameter int          NUM_SPEC   = 4,
    parameter logic [7:0]  SPEC_BASE  = 8'h70,
    localparam int         SPEC_W     = NUM_SPEC * 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [15:0]               io_addr,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic [7:0]                io_wdata,
    output logic [7:0]                io_rdata,
    output logic                      cfg_unlocked,
    output logic [NUM_LDN-1:0]        dev_active,
    output logic [16*NUM_LDN-1:0]     dev_base,
    output logic [SPEC_W*NUM_LDN-1:0] dev_spec
);

    logic       idx_wr, dat_wr, cfg_wr, exit_req;
    logic [7:0] index_q, ldn_q;
    logic [7:0] bank_rd [NUM_LDN];
    logic [7:0] bank_sel_rd, reg_rd;

    assign idx_wr   = io_wr && (io_addr == INDEX_ADDR);
    assign dat_wr   = io_wr && (io_addr == DATA_ADDR);
    assign cfg_wr   = dat_wr && cfg_unlocked;
    assign exit_req = cfg_wr && (index_q == IDX_EXIT) && (io_wdata == VAL_EXIT);

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .exit_req (exit_req),
        .unlocked (cfg_unlocked)
    );

    // Index register: loaded only while the space is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= 8'h00;
        else if (idx_wr && cfg_unlocked)
            index_q <= io_wdata;
    end

    // Logical device selector at its global index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ldn_q <= 8'h00;
        else if (cfg_wr && index_q == IDX_LDN)
            ldn_q <= io_wdata;
    end

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
        sio_bank_regs #(
            .NUM_SPEC  (NUM_SPEC),
            .SPEC_BASE (SPEC_BASE)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_wr && ldn_q == 8'(g)),
            .idx     (index_q),
            .wdata   (io_wdata),
            .active  (dev_active[g]),
            .base    (dev_base[16*g +: 16]),
            .spec    (dev_spec[SPEC_W*g +: SPEC_W]),
            .rd_data (bank_rd[g])
        );
    end

    // Pick the selected bank's read data; out-of-range selectors read zero.
    always_comb begin
        bank_sel_rd = 8'h00;
        for (int g = 0; g < NUM_LDN; g++)
            if (ldn_q == 8'(g)) bank_sel_rd = bank_rd[g];
    end

    // Global register decode, falling through to the bank.
    always_comb begin
        case (index_q)
            IDX_LDN:   reg_rd = ldn_q;
            IDX_ID_HI: reg_rd = CHIP_ID[15:8];
            IDX_ID_LO: reg_rd = CHIP_ID[7:0];
            IDX_REV:   reg_rd = {4'h0, CHIP_REV};
            default:   reg_rd = bank_sel_rd;
        endcase
    end

    // Host read data: all ones unless an open port is read.
    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && cfg_unlocked) begin
            if (io_addr == INDEX_ADDR)     io_rdata = index_q;
            else if (io_addr == DATA_ADDR) io_rdata = reg_rd;
        end
    end

endmodule

// File: rtl/sio_cfg_chk.sv
// Property checker for the configuration port, bound to every instance.
// It observes the host ports, the lock flag, the bank outputs and the index.
module sio_cfg_chk #(
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F,
    parameter logic [15:0] CHIP_ID    = 16'h8716,
    parameter int          NUM_LDN    = 4,
    parameter int          NUM_SPEC   = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [15:0]                  io_addr,
    input logic                         io_wr,
    input logic                         io_rd,
    input logic [7:0]                   io_wdata,
    input logic [7:0]                   io_rdata,
    input logic                         cfg_unlocked,
    input logic [NUM_LDN-1:0]           dev_active,
    input logic [16*NUM_LDN-1:0]        dev_base,
    input logic [8*NUM_SPEC*NUM_LDN-1:0] dev_spec,
    input logic [7:0]                   cur_index
);

    AST_LOCKED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && io_rd) |-> io_rdata == 8'hFF); // R4

    AST_LOCKED_BANKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_unlocked |=> ($stable(dev_active) && $stable(dev_base) && $stable(dev_spec))); // R4

    AST_OPEN_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_unlocked) |-> $past(io_wr && io_addr == INDEX_ADDR && io_wdata == 8'h55)); // R2

    AST_CLOSE_ONLY_BY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_unlocked) |-> $past(io_wr && io_addr == DATA_ADDR && io_wdata == 8'h02 && cur_index == 8'h02)); // R11

    AST_ID_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_rd && io_addr == DATA_ADDR && cur_index == 8'h20) |-> io_rdata == CHIP_ID[15:8]); // R6

endmodule

bind sio_cfg_port sio_cfg_chk #(
    .INDEX_ADDR (INDEX_ADDR),
    .DATA_ADDR  (DATA_ADDR),
    .CHIP_ID    (CHIP_ID),
    .NUM_LDN    (NUM_LDN),
    .NUM_SPEC   (NUM_SPEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .cfg_unlocked (cfg_unlocked),
    .dev_active   (dev_active),
    .dev_base     (dev_base),
    .dev_spec     (dev_spec),
    .cur_index    (index_q)
);

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
// Self-checking bench: key handling, locking, and a sweep of every index
// in every bank against a model kept in the bench.
module tb_sio_cfg_port;

    localparam logic [15:0] IA  = 16'h002E;
    localparam logic [15:0] DA  = 16'h002F;
    localparam logic [15:0] CID = 16'h8716;
    localparam logic [3:0]  REV = 4'h3;
    localparam int          NL  = 4;
    localparam int          NS  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h0;
    logic [7:0] io_rdata;
    logic cfg_unlocked;
    logic [NL-1:0] dev_active;
    logic [16*NL-1:0] dev_base;
    logic [8*NS*NL-1:0] dev_spec;

    int checks = 0, errors = 0;
    logic [7:0] rd_cap;

    logic       m_act  [NL];
    logic [15:0] m_base [NL];
    logic [7:0] m_spec [NL][NS];

    sio_cfg_port #(
        .INDEX_ADDR (IA), .DATA_ADDR (DA), .CHIP_ID (CID), .CHIP_REV (REV),
        .NUM_LDN (NL), .NUM_SPEC (NS), .SPEC_BASE (8'h70)
    ) dut (
        .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
        .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
        .cfg_unlocked (cfg_unlocked), .dev_active (dev_active),
        .dev_base (dev_base), .dev_spec (dev_spec)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, capture read data, let the edge pass.
    task automatic bus(input logic w, input logic r, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
        #1 rd_cap = io_rdata;
        @(posedge clk);
        #1;
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic wr_idx(input logic [7:0] v); bus(1'b1, 1'b0, IA, v); endtask
    task automatic wr_dat(input logic [7:0] v); bus(1'b1, 1'b0, DA, v); endtask
    task automatic rd_dat(output logic [7:0] v); bus(1'b0, 1'b1, DA, 8'h00); v = rd_cap; endtask
    task automatic rd_idx(output logic [7:0] v); bus(1'b0, 1'b1, IA, 8'h00); v = rd_cap; endtask
    task automatic cfg_wr(input logic [7:0] i, input logic [7:0] v); wr_idx(i); wr_dat(v); endtask
    task automatic cfg_rd(input logic [7:0] i, output logic [7:0] v); wr_idx(i); rd_dat(v); endtask
    task automatic unlock(); wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h55); wr_idx(8'h55); endtask

    function automatic logic [7:0] spec_val(input int g, input int k);
        return 8'(g * 37 + k * 11 + 5);
    endfunction

    // Expected register contents from the requirements.
    function automatic logic [7:0] model(input int ldn, input int idx);
        logic [7:0] v;
        v = 8'h00;
        if (idx == 8'h07) v = 8'(ldn);
        else if (idx == 8'h20) v = CID[15:8];
        else if (idx == 8'h21) v = CID[7:0];
        else if (idx == 8'h22) v = {4'h0, REV};
        else if (ldn < NL) begin
            if (idx == 8'h30) v = {7'b0, m_act[ldn]};
            else if (idx == 8'h60) v = m_base[ldn][15:8];
            else if (idx == 8'h61) v = m_base[ldn][7:0];
            else if (idx >= 8'h70 && idx < 8'h70 + NS) v = m_spec[ldn][idx - 8'h70];
        end
        return v;
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int g = 0; g < NL; g++) begin
            m_act[g] = 1'b0; m_base[g] = 16'h0;
            for (int k = 0; k < NS; k++) m_spec[g][k] = 8'h00;
        end

        // R1 reset state
        chk("R1 unlocked", cfg_unlocked, 1'b0);
        chk("R1 active", dev_active, '0);
        chk("R1 base", dev_base, '0);
        chk("R1 spec", dev_spec, '0);

        // R4 locked: reads all ones, writes ignored
        rd_dat(v); chk("R4 locked data read", v, 8'hFF);
        rd_idx(v); chk("R4 locked index read", v, 8'hFF);
        wr_idx(8'h30); wr_dat(8'hFF);
        chk("R4 locked write ignored", dev_active, '0);

        // R3 key on data port does not count
        wr_dat(8'h87); wr_dat(8'h01); wr_dat(8'h55); wr_dat(8'h55);
        chk("R3 key on data port", cfg_unlocked, 1'b0);
        // R3 wrong byte restarts
        wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'hAA); wr_idx(8'h55);
        chk("R3 broken key", cfg_unlocked, 1'b0);
        // R3 0x87 after mismatch is the first key byte
        wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h55); wr_idx(8'h87);
        wr_idx(8'h01); wr_idx(8'h55);
        chk("R3 before last byte", cfg_unlocked, 1'b0);
        wr_idx(8'h55);
        chk("R2 unlocked after key", cfg_unlocked, 1'b1);
        // R4 locked index writes did not load the index
        rd_idx(v); chk("R4 index untouched while locked", v, 8'h00);

        // R5 index readback
        wr_idx(8'h5A); rd_idx(v); chk("R5 index readback", v, 8'h5A);

        // R6 identity and revision, read-only
        cfg_rd(8'h20, v); chk("R6 id high", v, CID[15:8]);
        cfg_rd(8'h21, v); chk("R6 id low", v, CID[7:0]);
        cfg_rd(8'h22, v); chk("R6 revision", v, {4'h0, REV});
        cfg_wr(8'h20, 8'h00); cfg_wr(8'h21, 8'hFF); cfg_wr(8'h22, 8'hFF);
        cfg_rd(8'h20, v); chk("R6 id high after write", v, CID[15:8]);
        cfg_rd(8'h21, v); chk("R6 id low after write", v, CID[7:0]);
        cfg_rd(8'h22, v); chk("R6 revision after write", v, {4'h0, REV});

        // R7 R8 R9 R10 program every bank
        for (int g = 0; g < NL; g++) begin
            cfg_wr(8'h07, 8'(g));
            m_act[g] = g[0];
            cfg_wr(8'h30, {7'b1010101, g[0]});
            m_base[g] = 16'(16'h1234 * (g + 1));
            cfg_wr(8'h60, m_base[g][15:8]);
            cfg_wr(8'h61, m_base[g][7:0]);
            for (int k = 0; k < NS; k++) begin
                m_spec[g][k] = spec_val(g, k);
                cfg_wr(8'(8'h70 + k), m_spec[g][k]);
            end
        end
        for (int g = 0; g < NL; g++) begin
            chk("R8 dev_active", dev_active[g], m_act[g]);
            chk("R9 dev_base", dev_base[16*g +: 16], m_base[g]);
            for (int k = 0; k < NS; k++)
                chk("R10 dev_spec", dev_spec[8*(g*NS+k) +: 8], m_spec[g][k]);
        end
        // R5 R7 R13 sweep of every index in every bank
        for (int g = 0; g < NL; g++) begin
            cfg_wr(8'h07, 8'(g));
            for (int i = 0; i < 256; i++) begin
                cfg_rd(8'(i), v);
                chk("R13 R7 sweep", v, model(g, i));
            end
        end

        // R13 unmapped write ignored
        cfg_wr(8'h07, 8'h01);
        cfg_wr(8'h40, 8'hAA); cfg_rd(8'h40, v); chk("R13 unmapped", v, 8'h00);
        chk("R13 outputs unchanged", dev_base[16 +: 16], m_base[1]);

        // R7 out-of-range selector
        cfg_wr(8'h07, 8'h05);
        cfg_rd(8'h07, v); chk("R7 selector readback", v, 8'h05);
        cfg_wr(8'h30, 8'h01); cfg_wr(8'h60, 8'hEE);
        chk("R7 no bank written", dev_active, {m_act[3], m_act[2], m_act[1], m_act[0]});
        cfg_rd(8'h30, v); chk("R7 out-of-range read", v, 8'h00);

        // R12 same-cycle read and write of the data port
        cfg_wr(8'h07, 8'h00);
        wr_idx(8'h61);
        bus(1'b1, 1'b1, DA, 8'hC3);
        chk("R12 read sees old byte", rd_cap, m_base[0][7:0]);
        m_base[0][7:0] = 8'hC3;
        rd_dat(v); chk("R12 new byte next cycle", v, 8'hC3);
        // R12 same-cycle on the index port
        bus(1'b1, 1'b1, IA, 8'h02);
        chk("R12 index read sees old", rd_cap, 8'h61);

        // R11 non-exit value at index 0x02 keeps the space open
        wr_dat(8'h55);
        chk("R11 stays open", cfg_unlocked, 1'b1);
        // R11 R12 exit command with same-cycle read
        bus(1'b1, 1'b1, DA, 8'h02);
        chk("R12 exit read before lock", rd_cap, 8'h00);
        chk("R11 relocked", cfg_unlocked, 1'b0);
        rd_dat(v); chk("R11 locked read", v, 8'hFF);
        chk("R11 base kept", dev_base[0 +: 16], m_base[0]);
        chk("R11 spec kept", dev_spec[8*(3*NS+2) +: 8], m_spec[3][2]);

        // R2 reopen and check the index survived
        unlock();
        chk("R2 reopened", cfg_unlocked, 1'b1);
        rd_idx(v); chk("R5 index kept over lock", v, 8'h02);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 reset relocks", cfg_unlocked, 1'b0);
        chk("R1 reset base", dev_base, '0);
        chk("R1 reset active", dev_active, '0);
        unlock();
        cfg_rd(8'h07, v); chk("R1 selector cleared", v, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule